// File: doc/BRIEF.md
# Serial SAR ADC interface controller

This block is the digital side of a serial successive-approximation converter. A host lowers chip select and clocks the serial clock. It sends a run of zeros, then a one that marks the start, then a four-bit word that picks the analog inputs. The block decodes that word into one-hot positive and negative channel selects. It opens a sampling window of one and a half clock periods and then runs an 8-bit binary search. A trial code goes out to an external comparator, and the comparator answers with one bit per step.

Each decided bit is driven on the serial output at a falling clock edge, most significant bit first, behind one leading zero. A status line stays high while the search runs. Afterwards the word can be sent again, least significant bit first. With `SE_PIN = 1` a shift-enable input starts that replay. With `SE_PIN = 0` the replay starts by itself. The block clears whenever chip select is high at a clock edge. The serial output and the status line each come with a drive-enable. Both enables are off while chip select is high.

Front state machine (rising edge): HUNT, moving to ADDR on the start bit. ADDR moves to SAMPLE on the last address bit. SAMPLE moves to ARMED after one period, and ARMED holds until the block clears. Back state machine (falling edge): IDLE, moving to CONV when the front is ARMED. CONV moves to LSB_WAIT after bit 0. LSB_WAIT moves to REPLAY when replay is allowed. REPLAY moves to TAIL after bit 7.

Top module: `serial_sar_ctrl`

## Requirements
- R1: A rising clock edge with `cs_n_i` high clears the front state machine, and the next falling edge with `cs_n_i` high clears the back state machine. Both drive-enables are low whenever `cs_n_i` is high, and `busy_oe_o` is high whenever it is low.
- R2: While hunting, zeros on `din_i` are ignored. The first one sampled at a rising edge is the start bit.
- R3: The four bits after the start bit are, in arrival order: single-ended flag, odd/swap flag, select bit 1, select bit 0. Let `sel` be the two select bits and `odd` the odd/swap flag. The positive one-hot select is channel 2*sel+odd. The negative select is bit 8 (common input) for single-ended, and channel 2*sel+(1-odd) for differential. Both are valid from the rising edge that takes the last address bit until the block clears, and both are zero otherwise.
- R4: `track_o` is high from the rising edge that takes the last address bit up to the second falling edge after it, a span of 1.5 periods.
- R5: At that falling edge `busy_o` rises and the serial output is driven low as a leading zero.
- R6: On the next 8 falling edges the block decides bits 7 down to 0. The trial code is the bits decided so far plus a one at the current bit. The bit is kept when `cmp_i` is high, and each decision is driven on `dout_o` at its falling edge.
- R7: `busy_o` falls on the falling edge after the one that drives bit 0.
- R8: After the address word, `din_i` has no effect until the block clears.
- R9: If the comparator never answers high, the result and every streamed bit is zero.
- R10: With `SE_PIN = 1`, bit 0 stays on `dout_o` while `se_i` is high at falling edges. The first falling edge from busy falling onward with `se_i` low sends bit 1, and bits 2 to 7 follow on later edges whatever `se_i` does.
- R11: With `SE_PIN = 0`, bits 1 to 7 follow automatically, starting at the falling edge where busy falls.
- R12: After bit 7 of the replay, `dout_o` stays low until the block clears.
- R13: Raising `cs_n_i` mid-conversion aborts it, and a later conversion runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low chip select; high also clears |
| din_i | input | 1 | Serial data in (start bit and address word) |
| se_i | input | 1 | Shift enable; low starts the LSB-first replay (SE_PIN=1) |
| cmp_i | input | 1 | Comparator answer: input at or above trial code |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Drive-enable for dout_o |
| busy_o | output | 1 | Conversion in progress |
| busy_oe_o | output | 1 | Drive-enable for busy_o |
| track_o | output | 1 | Sampling window |
| trial_o | output | RES_BITS | Trial code for the comparator |
| pos_sel_o | output | NCH+1 | One-hot positive input select (bit NCH = common) |
| neg_sel_o | output | NCH+1 | One-hot negative input select (bit NCH = common) |

## Verification
Let the start bit be sampled at rising edge S. The selects and the window are due just after edge S+4, and the window closes at the falling edge that follows edge S+5. That same edge raises busy and drives the leading zero. Bit k then appears at the falling edge after rising edge S+13-k, and busy drops one falling edge after bit 0. The bench drives data-in and chip select between a falling edge and the next rising edge, and drives shift-enable before the falling edge. It samples 1 ns after each rising edge, so every value it compares is the settled result of the previous edge. A behavioural model counts edges from S and turns those offsets into the expected values.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        FR_HUNT,
        FR_ADDR,
        FR_SAMPLE,
        FR_ARMED
    } front_state_t;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_CONV,
        BK_LSB_WAIT,
        BK_REPLAY,
        BK_TAIL
    } back_state_t;

endpackage

// File: rtl/ssc_front_fsm.sv
// Rising-edge side: start-bit hunt, address capture, sampling window.
module ssc_front_fsm
    import ssc_pkg::*;
#(
    parameter int MUX_BITS = 4
) (
    input  logic                sclk_i,
    input  logic                cs_n_i,
    input  logic                din_i,
    output logic [MUX_BITS-1:0] cfg_o,
    output logic                cfg_valid_o,
    output logic                sampling_o,
    output logic                armed_o
);
    localparam int CW = (MUX_BITS > 1) ? $clog2(MUX_BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MUX_BITS - 1);

    front_state_t       state_q, state_d;
    logic [CW-1:0]      cnt_q, cnt_d;
    logic [MUX_BITS-1:0] cfg_q, cfg_d;

    // state register; chip select high at a rising edge clears everything
    always_ff @(posedge sclk_i) begin
        if (cs_n_i) begin
            state_q <= FR_HUNT;
            cnt_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cfg_q   <= cfg_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            FR_HUNT: begin
                if (din_i) begin
                    state_d = FR_ADDR;
                    cnt_d   = '0;
                end
            end
            FR_ADDR: begin
                cfg_d = {cfg_q[MUX_BITS-2:0], din_i};
                cnt_d = cnt_q + CW'(1);
                if (cnt_q == LAST) state_d = FR_SAMPLE;
            end
            FR_SAMPLE: state_d = FR_ARMED;
            FR_ARMED:  state_d = FR_ARMED;
            default:   state_d = FR_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        cfg_o       = cfg_q;
        cfg_valid_o = (state_q == FR_SAMPLE) || (state_q == FR_ARMED);
        sampling_o  = (state_q == FR_SAMPLE);
        armed_o     = (state_q == FR_ARMED);
    end

    // R2: a zero while hunting keeps the hunt going
    assert_zero_ignored_R2: assert property (@(posedge sclk_i) disable iff (cs_n_i)
        (state_q == FR_HUNT && !din_i) |=> (state_q == FR_HUNT));

    // R8: once armed, data in cannot move the front machine
    assert_armed_holds_R8: assert property (@(posedge sclk_i) disable iff (cs_n_i)
        (state_q == FR_ARMED) |=> (state_q == FR_ARMED));

    // R8: the captured word is frozen once valid
    assert_cfg_frozen_R8: assert property (@(posedge sclk_i) disable iff (cs_n_i)
        cfg_valid_o |=> $stable(cfg_q));

    // R4: the sampling state lasts exactly one rising edge
    assert_sample_one_cycle_R4: assert property (@(posedge sclk_i) disable iff (cs_n_i)
        (state_q == FR_SAMPLE) |=> (state_q == FR_ARMED));

endmodule

// File: rtl/ssc_mux_decode.sv
// Address word to one-hot positive / negative input selects.
module ssc_mux_decode #(
    parameter int SEL_BITS = 2,
    localparam int MUX_BITS = SEL_BITS + 2,
    localparam int NCH      = 2 << SEL_BITS
) (
    input  logic [MUX_BITS-1:0] cfg_i,
    input  logic                valid_i,
    output logic [NCH:0]        pos_sel_o,
    output logic [NCH:0]        neg_sel_o
);
    localparam int CHW = SEL_BITS + 1;

    logic                single_ended;
    logic                odd_swap;
    logic [SEL_BITS-1:0] sel;
    logic [CHW-1:0]      pos_idx, neg_idx;

    always_comb begin
        single_ended = cfg_i[MUX_BITS-1];
        odd_swap     = cfg_i[MUX_BITS-2];
        sel          = cfg_i[SEL_BITS-1:0];
        pos_idx      = {sel, odd_swap};
        neg_idx      = {sel, ~odd_swap};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        assign pos_sel_o[ch] = valid_i && (pos_idx == CHW'(ch));
        assign neg_sel_o[ch] = valid_i && !single_ended && (neg_idx == CHW'(ch));
    end

    // the common input can only ever be the negative side
    assign pos_sel_o[NCH] = 1'b0;
    assign neg_sel_o[NCH] = valid_i && single_ended;

endmodule

// File: rtl/ssc_sar_stream.sv
// Falling-edge side: successive approximation, live MSB-first stream,
// LSB-first replay and tail.
module ssc_sar_stream
    import ssc_pkg::*;
#(
    parameter int RES_BITS = 8,
    parameter bit SE_PIN   = 1'b1
) (
    input  logic                sclk_i,
    input  logic                cs_n_i,
    input  logic                armed_i,
    input  logic                cmp_i,
    input  logic                se_i,
    output logic                dout_o,
    output logic                active_o,
    output logic                idle_o,
    output logic                busy_o,
    output logic [RES_BITS-1:0] trial_o
);
    localparam int IW = $clog2(RES_BITS);
    localparam logic [IW-1:0] TOP_IDX = IW'(RES_BITS - 1);

    back_state_t         state_q, state_d;
    logic [IW-1:0]       idx_q, idx_d;
    logic [RES_BITS-1:0] result_q, result_d;
    logic                dout_q, dout_d;
    logic                busy_q, busy_d;
    logic                replay_go;

    // variant: replay under pin control or automatic
    if (SE_PIN) begin : g_se_pin
        assign replay_go = !se_i;
    end else begin : g_auto
        assign replay_go = 1'b1;
    end

    // state register; chip select high at a falling edge clears everything
    always_ff @(negedge sclk_i) begin
        if (cs_n_i) begin
            state_q  <= BK_IDLE;
            idx_q    <= '0;
            result_q <= '0;
            dout_q   <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            result_q <= result_d;
            dout_q   <= dout_d;
            busy_q   <= busy_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        result_d = result_q;
        dout_d   = dout_q;
        busy_d   = busy_q;
        unique case (state_q)
            BK_IDLE: begin
                if (armed_i) begin
                    state_d  = BK_CONV;
                    idx_d    = TOP_IDX;
                    result_d = '0;
                    dout_d   = 1'b0;
                    busy_d   = 1'b1;
                end
            end
            BK_CONV: begin
                result_d[idx_q] = cmp_i;
                dout_d          = cmp_i;
                if (idx_q == '0) begin
                    state_d = BK_LSB_WAIT;
                end else begin
                    idx_d = idx_q - IW'(1);
                end
            end
            BK_LSB_WAIT: begin
                busy_d = 1'b0;
                if (replay_go) begin
                    state_d = BK_REPLAY;
                    idx_d   = IW'(1);
                    dout_d  = result_q[1];
                end
            end
            BK_REPLAY: begin
                if (idx_q == TOP_IDX) begin
                    state_d = BK_TAIL;
                    dout_d  = 1'b0;
                end else begin
                    idx_d  = idx_q + IW'(1);
                    dout_d = result_q[idx_q + IW'(1)];
                end
            end
            BK_TAIL: dout_d = 1'b0;
            default: state_d = BK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dout_o   = dout_q;
        busy_o   = busy_q;
        active_o = (state_q != BK_IDLE);
        idle_o   = (state_q == BK_IDLE);
        trial_o  = result_q;
        if (state_q == BK_CONV) trial_o = result_q | (RES_BITS'(1) << idx_q);
    end

    // R6: status stays high through every decision
    assert_busy_in_conv_R6: assert property (@(negedge sclk_i) disable iff (cs_n_i)
        (state_q == BK_CONV) |-> busy_q);

    // R6: each decision stores the comparator answer at the current bit
    assert_bit_kept_R6: assert property (@(negedge sclk_i) disable iff (cs_n_i)
        (state_q == BK_CONV) |=> (result_q[$past(idx_q)] == $past(cmp_i)));

    // R7: status still high after bit 0, low one edge later
    assert_busy_after_lsb_R7: assert property (@(negedge sclk_i) disable iff (cs_n_i)
        (state_q == BK_CONV && idx_q == '0) |=> (busy_q && state_q == BK_LSB_WAIT));
    assert_busy_drop_R7: assert property (@(negedge sclk_i) disable iff (cs_n_i)
        (state_q == BK_LSB_WAIT) |=> !busy_q);

    // R10: without permission the LSB is held
    assert_lsb_hold_R10: assert property (@(negedge sclk_i) disable iff (cs_n_i)
        (state_q == BK_LSB_WAIT && !replay_go) |=> (state_q == BK_LSB_WAIT && $stable(dout_q)));

    // R12: tail drives low
    assert_tail_low_R12: assert property (@(negedge sclk_i) disable iff (cs_n_i)
        (state_q == BK_TAIL) |-> !dout_q);

endmodule

// File: rtl/serial_sar_ctrl.sv
module serial_sar_ctrl
    import ssc_pkg::*;
#(
    parameter int RES_BITS = 8,
    parameter int SEL_BITS = 2,
    parameter bit SE_PIN   = 1'b1,
    localparam int MUX_BITS = SEL_BITS + 2,
    localparam int NCH      = 2 << SEL_BITS
) (
    input  logic                sclk_i,
    input  logic                cs_n_i,
    input  logic                din_i,
    input  logic                se_i,
    input  logic                cmp_i,
    output logic                dout_o,
    output logic                dout_oe_o,
    output logic                busy_o,
    output logic                busy_oe_o,
    output logic                track_o,
    output logic [RES_BITS-1:0] trial_o,
    output logic [NCH:0]        pos_sel_o,
    output logic [NCH:0]        neg_sel_o
);
    logic [MUX_BITS-1:0] cfg;
    logic                cfg_valid;
    logic                sampling;
    logic                armed;
    logic                back_active;
    logic                back_idle;

    ssc_front_fsm #(.MUX_BITS(MUX_BITS)) u_front (
        .sclk_i      (sclk_i),
        .cs_n_i      (cs_n_i),
        .din_i       (din_i),
        .cfg_o       (cfg),
        .cfg_valid_o (cfg_valid),
        .sampling_o  (sampling),
        .armed_o     (armed)
    );

    ssc_mux_decode #(.SEL_BITS(SEL_BITS)) u_decode (
        .cfg_i     (cfg),
        .valid_i   (cfg_valid),
        .pos_sel_o (pos_sel_o),
        .neg_sel_o (neg_sel_o)
    );

    ssc_sar_stream #(.RES_BITS(RES_BITS), .SE_PIN(SE_PIN)) u_sar (
        .sclk_i   (sclk_i),
        .cs_n_i   (cs_n_i),
        .armed_i  (armed),
        .cmp_i    (cmp_i),
        .se_i     (se_i),
        .dout_o   (dout_o),
        .active_o (back_active),
        .idle_o   (back_idle),
        .busy_o   (busy_o),
        .trial_o  (trial_o)
    );

    // pins float while the chip is deselected
    always_comb begin
        dout_oe_o = !cs_n_i && back_active;
        busy_oe_o = !cs_n_i;
        track_o   = sampling || (armed && back_idle);
    end

    // R3: selects are one-hot and never the same input on both sides
    assert_pos_onehot_R3: assert property (@(posedge sclk_i) disable iff (cs_n_i)
        $onehot0(pos_sel_o));
    assert_neg_onehot_R3: assert property (@(posedge sclk_i) disable iff (cs_n_i)
        $onehot0(neg_sel_o));
    assert_sel_disjoint_R3: assert property (@(posedge sclk_i) disable iff (cs_n_i)
        ((pos_sel_o & neg_sel_o) == '0));

    // R5: the output driver turns on together with the status line
    assert_oe_with_busy_R5: assert property (@(negedge sclk_i) disable iff (cs_n_i)
        $rose(busy_o) |-> (dout_oe_o && !dout_o));

endmodule

// File: tb/serial_sar_ctrl_tb.sv
module serial_sar_ctrl_tb;
    localparam int RES  = 8;
    localparam int NCH  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       cs_n = 1'b1;
    logic       din  = 1'b0;
    logic       se   = 1'b1;
    logic [7:0] vin  = 8'h00;

    logic [1:0]     dout_w, oe_w, busy_w, boe_w, trk_w, cmp_w;
    logic [RES-1:0] trial_w [2];
    logic [NCH:0]   pos_w [2];
    logic [NCH:0]   neg_w [2];

    assign cmp_w[0] = (vin >= trial_w[0]);
    assign cmp_w[1] = (vin >= trial_w[1]);

    serial_sar_ctrl #(.RES_BITS(RES), .SEL_BITS(2), .SE_PIN(1'b1)) u_dut (
        .sclk_i(clk), .cs_n_i(cs_n), .din_i(din), .se_i(se), .cmp_i(cmp_w[0]),
        .dout_o(dout_w[0]), .dout_oe_o(oe_w[0]), .busy_o(busy_w[0]),
        .busy_oe_o(boe_w[0]), .track_o(trk_w[0]), .trial_o(trial_w[0]),
        .pos_sel_o(pos_w[0]), .neg_sel_o(neg_w[0]));

    serial_sar_ctrl #(.RES_BITS(RES), .SEL_BITS(2), .SE_PIN(1'b0)) u_dut_auto (
        .sclk_i(clk), .cs_n_i(cs_n), .din_i(din), .se_i(se), .cmp_i(cmp_w[1]),
        .dout_o(dout_w[1]), .dout_oe_o(oe_w[1]), .busy_o(busy_w[1]),
        .busy_oe_o(boe_w[1]), .track_o(trk_w[1]), .trial_o(trial_w[1]),
        .pos_sel_o(pos_w[1]), .neg_sel_o(neg_w[1]));

    int    nchk = 0;
    int    nerr = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string sc = "R1 reset";

    // behavioural model: edge counts relative to the start bit
    int       p = 0;
    int       s_edge = -1;
    int       addr_n = 0;
    logic [3:0] cfg_m = 4'h0;
    int       ld = -1;
    bit       m_busy = 1'b0;
    bit       m_en = 1'b0;
    bit       m_dout [2];
    int       m_rcnt [2];

    task automatic chk(input string req, input string sig, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h at edge %0d",
                     req, sc, sig, act, exp, p);
        end
    endtask

    task automatic model_pos();
        if (cs_n) begin
            s_edge = -1; addr_n = 0; cfg_m = 4'h0;
        end else if (s_edge < 0) begin
            if (din) begin s_edge = p; addr_n = 0; end
        end else if (addr_n < 4) begin
            cfg_m = {cfg_m[2:0], din};
            addr_n++;
        end
    endtask

    task automatic model_neg();
        int d;
        if (cs_n || s_edge < 0) begin
            if (cs_n) begin
                ld = -1; m_busy = 0; m_en = 0;
                for (int k = 0; k < 2; k++) begin m_dout[k] = 0; m_rcnt[k] = 0; end
            end
            return;
        end
        d = p - s_edge;
        if (d < 5) return;
        ld = d;
        if (d == 5) begin
            m_busy = 1; m_en = 1;
            for (int k = 0; k < 2; k++) m_dout[k] = 0;
        end else if (d <= 13) begin
            for (int k = 0; k < 2; k++) m_dout[k] = vin[13-d];
        end else begin
            m_busy = 0;
            for (int k = 0; k < 2; k++) begin
                if (m_rcnt[k] == 0) begin
                    if (k == 1 || !se) begin m_rcnt[k] = 1; m_dout[k] = vin[1]; end
                end else if (m_rcnt[k] <= 6) begin
                    m_rcnt[k]++; m_dout[k] = vin[m_rcnt[k]];
                end else if (m_rcnt[k] == 7) begin
                    m_rcnt[k] = 8; m_dout[k] = 0;
                end
            end
        end
    endtask

    function automatic logic [8:0] exp_pos(input logic [3:0] c);
        return 9'(1) << {c[1:0], c[2]};
    endfunction
    function automatic logic [8:0] exp_neg(input logic [3:0] c);
        if (c[3]) return 9'h100;
        return 9'(1) << {c[1:0], ~c[2]};
    endfunction

    task automatic check_all();
        int q;
        int idx;
        logic [7:0] tr;
        bit valid;
        string dtag;
        q = (s_edge >= 0) ? (p - s_edge) : -1;
        valid = (q >= 4);
        if (ld >= 5 && ld <= 12) begin
            idx = 12 - ld;
            tr = (vin & ~8'((1 << (idx + 1)) - 1)) | 8'(1 << idx);
        end else if (ld >= 13) tr = vin;
        else tr = 8'h00;
        for (int k = 0; k < 2; k++) begin
            chk("R1", "busy_oe", 32'(boe_w[k]), 32'(!cs_n));
            chk("R3", "pos_sel", 32'(pos_w[k]), valid ? 32'(exp_pos(cfg_m)) : 32'd0);
            chk("R3", "neg_sel", 32'(neg_w[k]), valid ? 32'(exp_neg(cfg_m)) : 32'd0);
            chk("R4", "track", 32'(trk_w[k]), 32'(q == 4 || q == 5));
            chk("R7", "busy", 32'(busy_w[k]), 32'(m_busy));
            chk("R5", "dout_oe", 32'(oe_w[k]), 32'(!cs_n && m_en));
            chk("R6", "trial", 32'(trial_w[k]), 32'(tr));
            if (!cs_n && m_en) begin
                if (ld == 5) dtag = "R5";
                else if (ld <= 13) dtag = "R6";
                else if (m_rcnt[k] == 8) dtag = "R12";
                else dtag = (k == 0) ? "R10" : "R11";
                chk(dtag, (k == 0) ? "dout se" : "dout auto", 32'(dout_w[k]), 32'(m_dout[k]));
            end
        end
    endtask

    task automatic tick(input logic din_v, input logic cs_v, input logic se_v);
        @(posedge clk);
        p++;
        model_pos();
        #1;
        if (chk_on) check_all();
        se = se_v;
        @(negedge clk);
        model_neg();
        #1;
        din  = din_v;
        cs_n = cs_v;
    endtask

    task automatic run_conv(input string name, input logic [7:0] v, input logic [3:0] cfg,
                            input int lead, input int se_lo, input int se_hi,
                            input bit noisy, input int abort_at);
        sc  = name;
        vin = v;
        tick(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < lead; i++) tick(1'b0, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b1);
        for (int i = 3; i >= 0; i--) tick(cfg[i], 1'b0, 1'b1);
        for (int c = 0; c < 28; c++) begin
            if (abort_at > 0 && c == abort_at) break;
            tick(noisy ? 1'($urandom) : 1'b0, 1'b0, !(c >= se_lo && c < se_hi));
        end
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin m_dout[i] = 0; m_rcnt[i] = 0; end
        tick(1'b0, 1'b1, 1'b1);
        tick(1'b0, 1'b1, 1'b1);
        chk_on = 1'b1;
        tick(1'b0, 1'b1, 1'b1);   // R1 reset state checked here
        run_conv("R2 single-ended ch5, LSB held then replay", 8'hA5, 4'b1110, 2, 16, 999, 1'b0, 0);
        run_conv("R3 differential 3/2, replay at once", 8'h3C, 4'b0101, 0, 0, 999, 1'b0, 0);
        run_conv("R9 zero input, differential 6/7", 8'h00, 4'b0011, 5, 4, 999, 1'b0, 0);
        run_conv("R8 noisy din, full scale, short se pulse", 8'hFF, 4'b1000, 1, 12, 13, 1'b1, 0);
        run_conv("R13 abort mid-conversion", 8'h5A, 4'b0110, 3, 0, 999, 1'b0, 6);
        run_conv("R13 conversion after abort", 8'h81, 4'b1011, 0, 14, 999, 1'b1, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule